// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block drives one successive-approximation analog-to-digital converter from a zero-wait-state APB-style slave port. Software programs a power-up delay, then writes the control word with the power bit set and an input channel number. That single write starts one conversion. The block waits the programmed number of clock periods. It then resolves the result one bit per clock, most significant bit first. Each trial code goes to an external DAC, and the external comparator answers whether the sampled input is at or above that code.

When the last bit resolves, the block stores the result, drops busy and raises a completion flag. The interrupt line is the flag gated by an enable bit. An interrupt handler typically reads the result and then writes zero to the control word. That one write clears the flag and removes converter power. The same zero write issued during a conversion abandons it. The converter clock is the bus clock, so every delay and bit time counts `clk` periods.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, every register reads zero: result (word 0x00), status (0x04), control (0x08) and delay (0x0C). The outputs `adcPwr`, `irq` and `chanValid` are low, and `dacCode` is zero.
- R2: A control write with bit 3 (power) set while idle starts a conversion. Status bit 0 (busy) reads 1 from the next cycle for exactly D + N cycles, where D is the delay register value and N is the result width.
- R3: The search runs MSB first. `dacCode` is nonzero only during the N resolving cycles and zero at all other times. With `cmpIn` high when the analog value is at or above `dacCode`, the stored result equals the analog value, saturated at 2^N - 1.
- R4: On the clock edge that resolves the last bit, three things happen together: the result register loads the value zero-extended to 32 bits, busy clears, and control bit 6 (done flag) sets.
- R5: `irq` is high exactly when control bit 6 and control bit 5 (interrupt enable) are both set.
- R6: A control write with bit 3 set while busy is ignored: no control field changes and the running conversion finishes with its own result.
- R7: A control write with bit 3 clear is always accepted and, if busy, aborts the conversion with busy low the next cycle. An abort leaves the result unchanged and does not set bit 6. Writing 0 to bit 6 clears the flag; writing 1 keeps its value, so software cannot set it.
- R8: Control bits 2:0 drive `chanSel`, and bit 3 drives `adcPwr`. `chanValid` is high only while powered with a channel number below NUM_CH.
- R9: The delay register keeps the low 6 bits of a write and reads zero above them. A delay of 0 starts bit resolution in the first cycle after the start write.
- R10: Offsets 0x10 to 0x1C read zero, and writes to them change no register.
- R11: The control register reads back channel in bits 2:0, power in bit 3, enable in bit 5 and flag in bit 6, with every other bit zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and converter clock |
| rstN | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while selected for a read |
| cmpIn | input | 1 | Comparator: 1 when the input is at or above the trial code |
| dacCode | output | RES_W | Trial code for the DAC |
| chanSel | output | 3 | Selected input channel |
| chanValid | output | 1 | Powered and the channel number exists |
| adcPwr | output | 1 | Converter power enable |
| irq | output | 1 | Conversion-complete interrupt |

## Verification
The assertions check the following on every cycle:
- a start write while idle raises busy;
- a start write while busy leaves the channel alone;
- a power-off write while busy ends the conversion;
- resolving the last bit sets the flag;
- the interrupt never shows without the flag;
- the DAC code is zero whenever the block is idle.

Other behaviour needs the bench scenarios:
- a result that matches the analog value, including saturation and both ends of the range;
- the exact busy length for a given delay;
- a result left untouched by an abort;
- flag semantics that cannot be set by software;
- reads of undefined offsets.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // Word indices of the register map (byte offset / 4)
  localparam int IDX_RESULT = 0;
  localparam int IDX_STATUS = 1;
  localparam int IDX_CTRL   = 2;
  localparam int IDX_DELAY  = 3;

  // Control word bit positions
  localparam int BIT_PWR  = 3;
  localparam int BIT_IEN  = 5;
  localparam int BIT_FLAG = 6;

  localparam int CH_W  = 3;
  localparam int DLY_W = 6;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_CONV = 2'd2
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic start;  // load MSB trial
    logic step;   // resolve current bit
    logic abort;  // drop the search
  } dpCmd_t;

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int IDX_W  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [IDX_W-1:0]    regIdx,
  input  logic [7:0]          wdata,
  input  logic                lastBit,
  output dpCmd_t              cmd,
  output logic                busy,
  output logic [CH_W-1:0]     chSel,
  output logic                chValid,
  output logic                pwrOn,
  output logic                irqEn,
  output logic                doneFlag,
  output logic [DLY_W-1:0]    delayVal
);

  phase_t            phase;
  logic [DLY_W-1:0]  waitCnt;
  logic              ctrlHit, dlyHit;
  logic              startReq, abortReq, acceptCtrl, finish;
  logic              waitDone;
  wire               unusedCtrlBits = &{1'b0, wdata[7], wdata[4]};

  assign ctrlHit    = regWr && (regIdx == IDX_W'(IDX_CTRL));
  assign dlyHit     = regWr && (regIdx == IDX_W'(IDX_DELAY));
  assign busy       = (phase != PH_IDLE);
  assign startReq   = ctrlHit && wdata[BIT_PWR] && !busy;
  assign abortReq   = ctrlHit && !wdata[BIT_PWR] && busy;
  assign acceptCtrl = ctrlHit && !(wdata[BIT_PWR] && busy);
  assign waitDone   = (phase == PH_WAIT) && (waitCnt == '0) && !abortReq;

  always_comb begin
    cmd       = '0;
    cmd.start = (startReq && (delayVal == '0)) || waitDone;
    cmd.step  = (phase == PH_CONV) && !abortReq;
    cmd.abort = abortReq;
  end

  assign finish  = cmd.step && lastBit;
  assign chValid = pwrOn && (int'(chSel) < NUM_CH);

  // Control and delay registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chSel    <= '0;
      pwrOn    <= 1'b0;
      irqEn    <= 1'b0;
      doneFlag <= 1'b0;
      delayVal <= '0;
    end else begin
      if (acceptCtrl) begin
        chSel    <= wdata[CH_W-1:0];
        pwrOn    <= wdata[BIT_PWR];
        irqEn    <= wdata[BIT_IEN];
        doneFlag <= doneFlag & wdata[BIT_FLAG];
      end else if (finish) begin
        doneFlag <= 1'b1;
      end
      if (dlyHit) delayVal <= wdata[DLY_W-1:0];
    end
  end

  // Phase sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      waitCnt <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (startReq) begin
            if (delayVal == '0) begin
              phase <= PH_CONV;
            end else begin
              phase   <= PH_WAIT;
              waitCnt <= delayVal - 1'b1;
            end
          end
        end
        PH_WAIT: begin
          if (abortReq)            phase   <= PH_IDLE;
          else if (waitCnt == '0)  phase   <= PH_CONV;
          else                     waitCnt <= waitCnt - 1'b1;
        end
        PH_CONV: begin
          if (abortReq || lastBit) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              cmpIn,
  output logic [RES_W-1:0]  dacCode,
  output logic [RES_W-1:0]  result,
  output logic              lastBit
);

  localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] trial, mask, nextTrial;

  // Per-bit next trial: decided bit takes comparator, bit below it is tried
  for (genvar gi = 0; gi < RES_W; gi++) begin : g_bit
    if (gi < RES_W - 1) begin : g_inner
      assign nextTrial[gi] = mask[gi] ? cmpIn : (mask[gi+1] ? 1'b1 : trial[gi]);
    end else begin : g_top
      assign nextTrial[gi] = mask[gi] ? cmpIn : trial[gi];
    end
  end

  assign dacCode = trial;
  assign lastBit = mask[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trial  <= '0;
      mask   <= '0;
      result <= '0;
    end else if (cmd.abort) begin
      trial <= '0;
      mask  <= '0;
    end else if (cmd.start) begin
      trial <= MSB_ONLY;
      mask  <= MSB_ONLY;
    end else if (cmd.step) begin
      if (mask[0]) begin
        result <= nextTrial;
        trial  <= '0;
        mask   <= '0;
      end else begin
        trial <= nextTrial;
        mask  <= mask >> 1;
      end
    end
  end

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              cmpIn,
  output logic [RES_W-1:0]  dacCode,
  output logic [2:0]        chanSel,
  output logic              chanValid,
  output logic              adcPwr,
  output logic              irq
);

  localparam int IDX_W = ADDR_W - 2;

  dpCmd_t            cmd;
  logic [IDX_W-1:0]  regIdx;
  logic              regWr, ctrlWrite, busy, lastBit;
  logic              irqEn, ctrlFlag;
  logic [DLY_W-1:0]  delayVal;
  logic [RES_W-1:0]  result;
  logic [31:0]       readMux;
  wire               unusedTopBits = &{1'b0, pwdata[31:8], paddr[1:0]};

  assign regIdx    = paddr[ADDR_W-1:2];
  assign regWr     = psel && penable && pwrite;
  assign ctrlWrite = regWr && (regIdx == IDX_W'(IDX_CTRL));

  sar_ctrl #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regIdx   (regIdx),
    .wdata    (pwdata[7:0]),
    .lastBit  (lastBit),
    .cmd      (cmd),
    .busy     (busy),
    .chSel    (chanSel),
    .chValid  (chanValid),
    .pwrOn    (adcPwr),
    .irqEn    (irqEn),
    .doneFlag (ctrlFlag),
    .delayVal (delayVal)
  );

  sar_datapath #(.RES_W(RES_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .cmpIn   (cmpIn),
    .dacCode (dacCode),
    .result  (result),
    .lastBit (lastBit)
  );

  assign irq = ctrlFlag && irqEn;

  always_comb begin
    readMux = '0;
    unique case (regIdx)
      IDX_W'(IDX_RESULT): readMux = 32'(result);
      IDX_W'(IDX_STATUS): readMux = 32'(busy);
      IDX_W'(IDX_CTRL):   readMux = 32'({ctrlFlag, irqEn, 1'b0, adcPwr, chanSel});
      IDX_W'(IDX_DELAY):  readMux = 32'(delayVal);
      default:            readMux = '0;
    endcase
  end

  assign prdata = (psel && !pwrite) ? readMux : '0;

endmodule

// File: rtl/sar_adc_chk.sv
module sar_adc_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             lastBit,
  input logic             ctrlWr,
  input logic             wrPwr,
  input logic             flag,
  input logic             irq,
  input logic [2:0]       chanSel,
  input logic [RES_W-1:0] dacCode
);

  // R2: start while idle makes the block busy
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && ctrlWr && wrPwr) |=> busy);

  // R6: start while busy keeps channel and conversion
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastBit && ctrlWr && wrPwr) |=> (busy && $stable(chanSel)));

  // R7: power-off write while busy aborts
  a_r7_abort: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ctrlWr && !wrPwr) |=> !busy);

  // R4: resolving the last bit sets the flag and ends busy
  a_r4_done_flag: assert property (@(posedge clk) disable iff (!rstN)
    (busy && lastBit && !(ctrlWr && !wrPwr)) |=> (!busy && flag));

  // R5: interrupt only with flag
  a_r5_irq_flag: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> flag);

  // R3: DAC code rests at zero while idle
  a_r3_idle_dac: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (dacCode == '0));

endmodule

bind sar_adc_ctrl sar_adc_chk #(.RES_W(RES_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .lastBit (lastBit),
  .ctrlWr  (ctrlWrite),
  .wrPwr   (pwdata[3]),
  .flag    (ctrlFlag),
  .irq     (irq),
  .chanSel (chanSel),
  .dacCode (dacCode)
);

// File: tb/sim_sar_adc_ctrl.sv
`timescale 1ns/1ps
module sim_sar_adc_ctrl;

  localparam int N     = 10;
  localparam int NCH   = 6;
  localparam int MAXV  = (1 << N) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [4:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        cmpIn;
  logic [N-1:0] dacCode;
  logic [2:0]  chanSel;
  logic        chanValid, adcPwr, irq;

  int vin = 0;
  int nChecks = 0;
  int nFails = 0;
  bit cmpOn = 1'b0;

  always #2 clk = ~clk;

  assign cmpIn = (int'(dacCode) <= vin);

  sar_adc_ctrl #(.RES_W(N), .NUM_CH(NCH), .ADDR_W(5)) u0 (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .cmpIn(cmpIn),
    .dacCode(dacCode), .chanSel(chanSel), .chanValid(chanValid),
    .adcPwr(adcPwr), .irq(irq)
  );

  // Behavioural reference model
  int mBusy, mDelay, mResult, mCh;
  bit mPwr, mIe, mFlag;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy = 0; mDelay = 0; mResult = 0; mCh = 0;
      mPwr = 0; mIe = 0; mFlag = 0;
    end else if (psel && penable && pwrite && paddr[4:2] == 3'd2) begin
      if (mBusy > 0 && pwdata[3]) begin
        mBusy = mBusy - 1;
        if (mBusy == 0) begin mResult = (vin > MAXV) ? MAXV : vin; mFlag = 1; end
      end else begin
        mBusy = 0;
        mCh = int'(pwdata[2:0]); mPwr = pwdata[3]; mIe = pwdata[5];
        mFlag = mFlag && pwdata[6];
        if (pwdata[3]) mBusy = mDelay + N;
      end
    end else begin
      if (psel && penable && pwrite && paddr[4:2] == 3'd3) mDelay = int'(pwdata[5:0]);
      if (mBusy > 0) begin
        mBusy = mBusy - 1;
        if (mBusy == 0) begin mResult = (vin > MAXV) ? MAXV : vin; mFlag = 1; end
      end
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison of the port outputs (R3 R5 R8)
  always @(negedge clk) begin
    if (cmpOn) begin
      check("R5 irq", irq, mFlag && mIe);
      check("R8 outputs", {adcPwr, chanValid, chanSel},
            {mPwr, mPwr && (mCh < NCH), 3'(mCh)});
      check("R3 dac active", dacCode != 0, (mBusy > 0) && (mBusy <= N));
    end
  end

  task automatic apbWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apbRead(input logic [4:0] a, input string req, input longint exp);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1;
    #1 check(req, prdata, exp);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic runConv(input int v, input logic [31:0] word);
    vin = v;
    apbWrite(5'h08, word);
    apbRead(5'h04, "R2 busy after start", 1);
    repeat (mDelay + N) @(negedge clk);
    apbRead(5'h04, "R2 busy cleared", 0);
    apbRead(5'h00, "R3 result", (v > MAXV) ? MAXV : v);
    apbRead(5'h08, "R4 flag set", {mFlag, mIe, 1'b0, mPwr, 3'(mCh)});
  endtask

  task automatic finishRun;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    cmpOn = 1;
    // R1 reset state
    apbRead(5'h00, "R1 result", 0);
    apbRead(5'h04, "R1 status", 0);
    apbRead(5'h08, "R1 ctrl", 0);
    apbRead(5'h0C, "R1 delay", 0);
    check("R1 dac", dacCode, 0);
    // R9 delay width
    apbWrite(5'h0C, 32'hFFFF_FFFF);
    apbRead(5'h0C, "R9 delay masked", 32'h3F);
    apbWrite(5'h0C, 8);
    apbRead(5'h0C, "R9 delay", 8);
    // R2 R3 R4 R5 conversions with interrupt enabled
    runConv(300, 32'h28);
    check("R5 irq high", irq, 1);
    apbWrite(5'h08, 0);
    apbRead(5'h08, "R7 zero write clears", 0);
    check("R7 irq low", irq, 0);
    runConv(0, 32'h29);
    runConv(MAXV, 32'h2A);
    runConv(2000, 32'h2B);   // saturation
    runConv(512, 32'h2C);
    runConv(341, 32'h2D);
    // R9 zero delay
    apbWrite(5'h0C, 0);
    runConv(777, 32'h29);
    apbWrite(5'h0C, 8);
    // R6 start while busy ignored
    apbWrite(5'h08, 32'h0);
    vin = 700;
    apbWrite(5'h08, 32'h29);
    apbWrite(5'h08, 32'h2D);
    repeat (mDelay + N) @(negedge clk);
    apbRead(5'h00, "R6 result kept", 700);
    apbRead(5'h08, "R6 ctrl unchanged", 32'h69);
    // R7 abort mid-conversion
    apbWrite(5'h08, 32'h0);
    vin = 100;
    apbWrite(5'h08, 32'h28);
    repeat (12) @(negedge clk);
    apbWrite(5'h08, 32'h0);
    apbRead(5'h04, "R7 abort idle", 0);
    apbRead(5'h00, "R7 result unchanged", 700);
    apbRead(5'h08, "R7 no flag", 0);
    // R7 flag not settable by software
    apbWrite(5'h08, 32'h40);
    apbRead(5'h08, "R7 flag not set", 0);
    // R5 enable off, flag kept by writing 1
    runConv(55, 32'h0B);
    check("R5 irq masked", irq, 0);
    apbWrite(5'h08, 32'h60);
    apbRead(5'h08, "R11 ctrl readback", 32'h60);
    check("R5 irq on enable", irq, 1);
    apbWrite(5'h08, 32'h20);
    check("R7 flag cleared", irq, 0);
    // R8 invalid and valid channel
    apbWrite(5'h08, 32'h0F);
    check("R8 invalid channel", chanValid, 0);
    apbWrite(5'h08, 32'h0);
    apbWrite(5'h08, 32'h0D);
    check("R8 valid channel", chanValid, 1);
    repeat (mDelay + N + 1) @(negedge clk);
    apbWrite(5'h08, 32'h0);
    // R10 undefined offsets
    apbWrite(5'h10, 32'hFFFF_FFFF);
    apbWrite(5'h1C, 32'hFFFF_FFFF);
    apbRead(5'h10, "R10 undefined read", 0);
    apbRead(5'h18, "R10 undefined read", 0);
    apbRead(5'h0C, "R10 delay untouched", 8);
    apbRead(5'h08, "R10 ctrl untouched", 0);
    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule